// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

A down-counting watchdog with a small register window. Software arms it by setting a run bit. From then on the counter loses one count on every qualified tick, and a prescaler outside the block supplies those ticks. To keep the system alive, software writes a two-half key to the service register before the count runs out. The key reloads the counter from the programmed timeout field. When the remaining count lands on a programmed pre-timeout value, a latched interrupt flag is set. When the count is used up, the block holds a system-reset request and drives its external watchdog output until the next system reset.

Several settings can be written only once. The run bit cannot be cleared once it is set, except while the debug-mode input is high. The interrupt enable and the interrupt count value freeze after the first write to their register. The power-down enable bit also freezes after its first write. A control-register write can request a one-cycle software reset, or can force the external output active until power-on reset. Reset-cause flags live in the power-on domain, so software can read after a system reset why that reset happened. Separate keep bits decide whether counting goes on while the wait, stop and debug mode inputs are high.

Top module: `wdk_watchdog`

## Requirements
- R1: After power-on reset the control register (address 0) reads 0xFF32: run bit0=0, wait-keep bit1=1, stop-keep bit2=0, debug-keep bit3=0, software-reset bit4 reads 1, output-assert bit5 reads 1, timeout field bits 15:8 = 0xFF. The interrupt register (address 2) reads 0x0400, the status register (address 3) reads 0x0101 (power-down enable bit0, power-on cause bit8), and the counter (read at address 1) is 0.
- R2: Writing 0x5555 and then 0xAAAA to address 1 while running reloads the counter with the timeout field. Any other value written between the two halves cancels the sequence and the counter is not reloaded.
- R3: Writing 0 to run bit0 has no effect once the bit is set, except while dbg_mode is high, when the bit clears.
- R4: A timeout field written to address 0 reaches the counter only when run goes from 0 to 1 or when a service sequence completes.
- R5: The first write to address 2 sets the interrupt enable (bit0) and count (bits 15:8) and locks both until system reset. When an active tick brings the count to that value with the enable set, flag bit1 and irq go high. Writing 1 to bit1 clears the flag.
- R6: The power-down enable (address 3 bit0, output pwr_dn_en) takes the first written value and then ignores writes until system reset.
- R7: Writing 0 to control bit4 makes sw_rst_req high for exactly one cycle. The bit still reads 1, and status bit10 (software cause) is set with the other cause bits cleared.
- R8: Writing 0 to control bit5 drives wd_out high and makes bit5 read 0. This survives system reset and clears only on power-on reset.
- R9: When an active tick takes the count from 1 (or 0) to 0, sys_rst_req and wd_out go high and stay high until system reset. Status bit9 (timeout cause) is set and the other cause bits are cleared. The cause bits survive system reset.
- R10: While wait_mode, stop_mode or dbg_mode is high and the matching keep bit is 0, ticks do not change the count. With the keep bit at 1, counting goes on.
- R11: Each active tick (run set, not suspended, not expired, tick high) lowers the count by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| tick | input | 1 | Count enable from the external prescaler |
| wait_mode | input | 1 | Core is in wait mode |
| stop_mode | input | 1 | Core is in stop mode |
| dbg_mode | input | 1 | Core is halted for debug |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| irq | output | 1 | Pre-timeout interrupt |
| sys_rst_req | output | 1 | Timeout system-reset request |
| sw_rst_req | output | 1 | One-cycle software reset request |
| wd_out | output | 1 | External watchdog output, active high |
| pwr_dn_en | output | 1 | Power-down enable setting |

## Verification
The bench builds the block with an 8-bit counter, a 0xFF default timeout, a default interrupt count of 4, the pre-timeout interrupt variant included, and the low key half expected first. Because the full 8-bit counter is in place, both the 0xFF reset value and short programmed timeouts of 6 to 60 ticks can be checked. Expiry, the interrupt crossing and random mode/keep combinations therefore fit into a few hundred cycles. The interrupt count of 10 lies well inside the reload range, so the flag can be observed one tick before it and exactly at it.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
   localparam int REG_W = 16;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_SVC  = 2'd1;
   localparam logic [1:0] A_IRQ  = 2'd2;
   localparam logic [1:0] A_STAT = 2'd3;

   localparam int C_RUN   = 0;
   localparam int C_WAIT  = 1;
   localparam int C_STOP  = 2;
   localparam int C_DBG   = 3;
   localparam int C_SWRST = 4;
   localparam int C_OUTA  = 5;
   localparam int FLD_LSB = 8;

   localparam int I_EN   = 0;
   localparam int I_FLAG = 1;

   localparam int S_PDE  = 0;
   localparam int S_POR  = 8;
   localparam int S_TOUT = 9;
   localparam int S_SW   = 10;

   typedef struct packed {
      logic sw;
      logic tout;
      logic por;
   } cause_t;
endpackage

// File: rtl/wdk_key.sv
module wdk_key #(
   parameter logic [31:0] KEY      = 32'hAAAA5555,
   parameter bit          LO_FIRST = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr,
   input  logic [wdk_pkg::REG_W-1:0] wdata,
   output logic                      done
);
   localparam logic [15:0] FIRST  = LO_FIRST ? KEY[15:0]  : KEY[31:16];
   localparam logic [15:0] SECOND = LO_FIRST ? KEY[31:16] : KEY[15:0];

   if (FIRST == SECOND) begin : g_bad_key
      $error("key halves must differ");
   end

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else if (wr) armed <= (wdata == FIRST);
   end

   assign done = wr && armed && (wdata == SECOND);

   // R2: a completed sequence always leaves the detector disarmed
   assert_done_disarms_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !armed);
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
   parameter int CW      = 8,
   parameter bit PRE_IRQ = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          go,
   input  logic          tick,
   input  logic [CW-1:0] icnt,
   output logic [CW-1:0] cnt,
   output logic          expired,
   output logic          expire_evt,
   output logic          hit
);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic active;
   assign active     = go && tick && !expired && !load;
   assign expire_evt = active && (cnt <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         expired <= 1'b0;
      end else if (load) begin
         cnt <= load_val;
      end else if (active) begin
         if (cnt <= ONE) begin
            cnt     <= '0;
            expired <= 1'b1;
         end else begin
            cnt <= cnt - ONE;
         end
      end
   end

   if (PRE_IRQ) begin : g_pre
      assign hit = active && (cnt != '0) && ((cnt - ONE) == icnt);
   end else begin : g_nopre
      logic unused_icnt;
      assign unused_icnt = ^icnt;
      assign hit = 1'b0;
   end

   assert_expire_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      expired |=> expired);

   assert_step_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (go && tick && !expired && !load && cnt > ONE) |=> (cnt == $past(cnt) - ONE));

   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !go) |=> $stable(cnt));
endmodule

// File: rtl/wdk_cause.sv
module wdk_cause (
   input  logic            clk,
   input  logic            por_n,
   input  logic            tout_evt,
   input  logic            sw_evt,
   input  logic            out_evt,
   output wdk_pkg::cause_t cause,
   output logic            out_hold
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cause    <= '{sw: 1'b0, tout: 1'b0, por: 1'b1};
         out_hold <= 1'b0;
      end else begin
         if (tout_evt)    cause <= '{sw: 1'b0, tout: 1'b1, por: 1'b0};
         else if (sw_evt) cause <= '{sw: 1'b1, tout: 1'b0, por: 1'b0};
         if (out_evt) out_hold <= 1'b1;
      end
   end

   assert_out_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
      out_hold |=> out_hold);

   assert_one_cause_R9: assert property (@(posedge clk) disable iff (!por_n)
      $countones({cause.sw, cause.tout, cause.por}) == 1);
endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog #(
   parameter int           CW       = 8,
   parameter logic [CW-1:0] DEF_TOUT = CW'(8'hFF),
   parameter logic [CW-1:0] DEF_ICNT = CW'(8'h04),
   parameter logic [31:0]  KEY      = 32'hAAAA5555,
   parameter bit           LO_FIRST = 1'b1,
   parameter bit           PRE_IRQ  = 1'b1
) (
   input  logic        clk,
   input  logic        por_n,
   input  logic        sys_rst_n,
   input  logic        tick,
   input  logic        wait_mode,
   input  logic        stop_mode,
   input  logic        dbg_mode,
   input  logic        wr_en,
   input  logic [1:0]  addr,
   input  logic [15:0] wdata,
   output logic [15:0] rdata,
   output logic        irq,
   output logic        sys_rst_req,
   output logic        sw_rst_req,
   output logic        wd_out,
   output logic        pwr_dn_en
);
   import wdk_pkg::*;

   if (CW < 2 || CW > REG_W - FLD_LSB) begin : g_bad_cw
      $error("CW must lie in 2..8");
   end

   logic rst_all_n;
   assign rst_all_n = sys_rst_n & por_n;

   logic wr_ctrl, wr_svc, wr_irq, wr_stat;
   assign wr_ctrl = wr_en && (addr == A_CTRL);
   assign wr_svc  = wr_en && (addr == A_SVC);
   assign wr_irq  = wr_en && (addr == A_IRQ);
   assign wr_stat = wr_en && (addr == A_STAT);

   logic          run, keep_wait, keep_stop, keep_dbg;
   logic [CW-1:0] tout_val, wr_field;
   logic          irq_en, irq_flag, irq_lock;
   logic [CW-1:0] irq_cnt;
   logic          pde, pde_lock, sw_pulse;

   assign wr_field = wdata[FLD_LSB +: CW];

   always_ff @(posedge clk or negedge rst_all_n) begin
      if (!rst_all_n) begin
         run       <= 1'b0;
         keep_wait <= 1'b1;
         keep_stop <= 1'b0;
         keep_dbg  <= 1'b0;
         tout_val  <= DEF_TOUT;
         sw_pulse  <= 1'b0;
      end else begin
         sw_pulse <= wr_ctrl && !wdata[C_SWRST];
         if (wr_ctrl) begin
            keep_wait <= wdata[C_WAIT];
            keep_stop <= wdata[C_STOP];
            keep_dbg  <= wdata[C_DBG];
            tout_val  <= wr_field;
            if (wdata[C_RUN])  run <= 1'b1;
            else if (dbg_mode) run <= 1'b0;
         end
      end
   end

   // key sequence
   logic svc_done;
   wdk_key #(.KEY(KEY), .LO_FIRST(LO_FIRST)) i_key (
      .clk(clk), .rst_n(rst_all_n), .wr(wr_svc), .wdata(wdata), .done(svc_done)
   );

   // counter
   logic          run_set, load, go, suspend, expired, expire_evt, hit;
   logic [CW-1:0] load_val, cnt;

   assign run_set  = wr_ctrl && wdata[C_RUN] && !run;
   assign load     = run_set || (svc_done && run);
   assign load_val = run_set ? wr_field : tout_val;
   assign suspend  = (wait_mode && !keep_wait) || (stop_mode && !keep_stop) ||
                     (dbg_mode && !keep_dbg);
   assign go       = run && !suspend;

   wdk_count #(.CW(CW), .PRE_IRQ(PRE_IRQ)) i_count (
      .clk(clk), .rst_n(rst_all_n), .load(load), .load_val(load_val), .go(go),
      .tick(tick), .icnt(irq_cnt), .cnt(cnt), .expired(expired),
      .expire_evt(expire_evt), .hit(hit)
   );

   // interrupt settings, write-once until system reset
   always_ff @(posedge clk or negedge rst_all_n) begin
      if (!rst_all_n) begin
         irq_en   <= 1'b0;
         irq_cnt  <= DEF_ICNT;
         irq_lock <= 1'b0;
         irq_flag <= 1'b0;
      end else begin
         if (wr_irq && !irq_lock) begin
            irq_en   <= wdata[I_EN];
            irq_cnt  <= wr_field;
            irq_lock <= 1'b1;
         end
         if (hit && irq_en)                 irq_flag <= 1'b1;
         else if (wr_irq && wdata[I_FLAG])  irq_flag <= 1'b0;
      end
   end

   // power-down enable, write-once
   always_ff @(posedge clk or negedge rst_all_n) begin
      if (!rst_all_n) begin
         pde      <= 1'b1;
         pde_lock <= 1'b0;
      end else if (wr_stat && !pde_lock) begin
         pde      <= wdata[S_PDE];
         pde_lock <= 1'b1;
      end
   end

   // reset cause and sticky output, power-on domain
   cause_t cause;
   logic   out_hold;
   wdk_cause i_cause (
      .clk(clk), .por_n(por_n), .tout_evt(expire_evt), .sw_evt(sw_pulse),
      .out_evt(wr_ctrl && !wdata[C_OUTA]), .cause(cause), .out_hold(out_hold)
   );

   // read mux
   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL: begin
            rdata[C_RUN]           = run;
            rdata[C_WAIT]          = keep_wait;
            rdata[C_STOP]          = keep_stop;
            rdata[C_DBG]           = keep_dbg;
            rdata[C_SWRST]         = 1'b1;
            rdata[C_OUTA]          = !out_hold;
            rdata[FLD_LSB +: CW]   = tout_val;
         end
         A_SVC:  rdata[CW-1:0] = cnt;
         A_IRQ: begin
            rdata[I_EN]            = irq_en;
            rdata[I_FLAG]          = irq_flag;
            rdata[FLD_LSB +: CW]   = irq_cnt;
         end
         default: begin
            rdata[S_PDE]  = pde;
            rdata[S_POR]  = cause.por;
            rdata[S_TOUT] = cause.tout;
            rdata[S_SW]   = cause.sw;
         end
      endcase
   end

   assign irq         = irq_flag && irq_en;
   assign sys_rst_req = expired;
   assign sw_rst_req  = sw_pulse;
   assign wd_out      = expired || out_hold;
   assign pwr_dn_en   = pde;

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   assert_run_sticky_R3: assert property (@(posedge clk) disable iff (!rst_all_n)
      (run && !dbg_mode) |=> run);

   assert_irq_locked_R5: assert property (@(posedge clk) disable iff (!rst_all_n)
      irq_lock |=> ($stable(irq_cnt) && $stable(irq_en)));

   assert_pde_locked_R6: assert property (@(posedge clk) disable iff (!rst_all_n)
      pde_lock |=> $stable(pde));

   assert_swrst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_all_n)
      sw_rst_req |=> !sw_rst_req);

   assert_tout_load_R4: assert property (@(posedge clk) disable iff (!rst_all_n)
      (wr_ctrl && run && !svc_done && !tick) |=> $stable(cnt));
endmodule

// File: tb/test_wdk_watchdog.sv
module test_wdk_watchdog;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        por_n = 1'b0, sys_rst_n = 1'b0, tick = 1'b0;
   logic        wait_mode = 1'b0, stop_mode = 1'b0, dbg_mode = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rdata;
   logic        irq, sys_rst_req, sw_rst_req, wd_out, pwr_dn_en;

   int n_chk = 0, n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   wdk_watchdog #(.CW(8), .DEF_TOUT(8'hFF), .DEF_ICNT(8'h04), .KEY(32'hAAAA5555),
                  .LO_FIRST(1'b1), .PRE_IRQ(1'b1)) i_wdk_watchdog (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick(tick),
      .wait_mode(wait_mode), .stop_mode(stop_mode), .dbg_mode(dbg_mode),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
      .sys_rst_req(sys_rst_req), .sw_rst_req(sw_rst_req), .wd_out(wd_out),
      .pwr_dn_en(pwr_dn_en)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         @(negedge clk);
         tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic service();
      wr(2'd1, 16'h5555);
      wr(2'd1, 16'hAAAA);
   endtask

   task automatic sys_reset();
      @(negedge clk); sys_rst_n = 1'b0;
      @(negedge clk); sys_rst_n = 1'b1;
   endtask

   task automatic po_reset();
      @(negedge clk); por_n = 1'b0; sys_rst_n = 1'b0;
      @(negedge clk); por_n = 1'b1; sys_rst_n = 1'b1;
   endtask

   // expected count after n ticks under given modes and keep bits {dbg,stop,wait}
   function automatic logic [15:0] exp_count(input int start, input int n,
                                             input logic [2:0] md, input logic [2:0] kp);
      logic susp;
      susp = |(md & ~kp);
      if (susp) return 16'(start);
      return (n >= start) ? 16'd0 : 16'(start - n);
   endfunction

   initial begin
      #(CLK_P * 100000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      por_n = 1'b1; sys_rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, v); chk("R1 ctrl", v, 16'hFF32);
      rd(2'd2, v); chk("R1 irq reg", v, 16'h0400);
      rd(2'd3, v); chk("R1 status", v, 16'h0101);
      rd(2'd1, v); chk("R1 count", v, 16'h0000);
      chk("R1 outputs", {12'd0, irq, sys_rst_req, sw_rst_req, wd_out}, 16'h0);

      // R4 timeout field deferred
      wr(2'd0, 16'h1432);
      rd(2'd1, v); chk("R4 no load while stopped", v, 16'd0);
      wr(2'd0, 16'h1433);
      rd(2'd1, v); chk("R4 load on enable", v, 16'd20);
      wr(2'd0, 16'h3233);
      rd(2'd1, v); chk("R4 no load on rewrite", v, 16'd20);
      ticks(5);
      rd(2'd1, v); chk("R11 decrement", v, 16'd15);

      // R2 service
      service();
      rd(2'd1, v); chk("R2 reload", v, 16'd50);
      ticks(3);
      wr(2'd1, 16'h5555); wr(2'd1, 16'h1234); wr(2'd1, 16'hAAAA);
      rd(2'd1, v); chk("R2 broken sequence", v, 16'd47);
      wr(2'd1, 16'hAAAA);
      rd(2'd1, v); chk("R2 second half alone", v, 16'd47);

      // R3 run lock and debug exception; R10 debug suspend
      wr(2'd0, 16'h3232);
      rd(2'd0, v); chk("R3 run stays", v, 16'h3233);
      dbg_mode = 1'b1;
      ticks(4);
      rd(2'd1, v); chk("R10 debug suspend", v, 16'd47);
      wr(2'd0, 16'h3232);
      rd(2'd0, v); chk("R3 clear in debug", v, 16'h3232);
      wr(2'd0, 16'h3233);
      rd(2'd1, v); chk("R4 reload on re-enable", v, 16'd50);
      dbg_mode = 1'b0;

      // R10 wait / stop
      wait_mode = 1'b1; ticks(2);
      rd(2'd1, v); chk("R10 wait keeps counting", v, 16'd48);
      wait_mode = 1'b0; stop_mode = 1'b1; ticks(2);
      rd(2'd1, v); chk("R10 stop suspends", v, 16'd48);
      wr(2'd0, 16'h3237); ticks(2);
      rd(2'd1, v); chk("R10 stop keep counts", v, 16'd46);
      stop_mode = 1'b0;

      // random modes and timeouts, R10 / R11
      for (int i = 0; i < 16; i++) begin
         int          tv, n;
         logic [2:0]  md, kp;
         tv = 12 + int'($urandom % 49);
         n  = int'($urandom % (tv - 1));
         md = 3'($urandom);
         kp = 3'($urandom);
         wr(2'd0, 16'(tv << 8) | 16'h0031 | 16'({kp, 1'b0}));
         service();
         wait_mode = md[0]; stop_mode = md[1]; dbg_mode = md[2];
         ticks(n);
         wait_mode = 1'b0; stop_mode = 1'b0; dbg_mode = 1'b0;
         rd(2'd1, v); chk("R10 R11 random count", v, exp_count(tv, n, md, kp));
      end

      // R5 interrupt
      wr(2'd2, 16'h0A01);
      wr(2'd2, 16'h0500);
      rd(2'd2, v); chk("R5 lock", v, 16'h0A01);
      wr(2'd0, 16'h3233);
      service();
      ticks(39);
      chk("R5 irq before point", {15'd0, irq}, 16'd0);
      ticks(1);
      chk("R5 irq at point", {15'd0, irq}, 16'd1);
      rd(2'd2, v); chk("R5 flag set", v, 16'h0A03);
      wr(2'd2, 16'h0002);
      rd(2'd2, v); chk("R5 flag cleared", v, 16'h0A01);
      chk("R5 irq low", {15'd0, irq}, 16'd0);

      // R6 power-down enable
      wr(2'd3, 16'h0000);
      rd(2'd3, v); chk("R6 first write", v, 16'h0100);
      wr(2'd3, 16'h0001);
      rd(2'd3, v); chk("R6 locked", v, 16'h0100);
      chk("R6 pin", {15'd0, pwr_dn_en}, 16'd0);

      // R9 timeout
      wr(2'd0, 16'h0633);
      service();
      ticks(5);
      rd(2'd1, v); chk("R9 count one", v, 16'd1);
      chk("R9 no request yet", {15'd0, sys_rst_req}, 16'd0);
      ticks(1);
      chk("R9 request", {14'd0, sys_rst_req, wd_out}, 16'h3);
      rd(2'd3, v); chk("R9 timeout cause", v, 16'h0200);
      ticks(2);
      chk("R9 request held", {15'd0, sys_rst_req}, 16'd1);
      sys_reset();
      rd(2'd3, v); chk("R9 cause survives", v, 16'h0201);
      chk("R9 request cleared", {14'd0, sys_rst_req, wd_out}, 16'h0);
      rd(2'd2, v); chk("R5 unlocked by reset", v, 16'h0400);
      wr(2'd2, 16'h0301);
      rd(2'd2, v); chk("R5 new write", v, 16'h0301);

      // R7 software reset
      wr(2'd0, 16'hFF22);
      #1 chk("R7 pulse", {15'd0, sw_rst_req}, 16'd1);
      @(negedge clk);
      #1 chk("R7 pulse ends", {15'd0, sw_rst_req}, 16'd0);
      rd(2'd0, v); chk("R7 readback", v, 16'hFF32);
      rd(2'd3, v); chk("R7 sw cause", v, 16'h0401);
      sys_reset();
      rd(2'd3, v); chk("R7 cause survives", v, 16'h0401);

      // R8 sticky output
      wr(2'd0, 16'hFF12);
      #1 chk("R8 output on", {15'd0, wd_out}, 16'd1);
      rd(2'd0, v); chk("R8 readback", v, 16'hFF12);
      sys_reset();
      #1 chk("R8 survives sys reset", {15'd0, wd_out}, 16'd1);
      po_reset();
      #1 chk("R8 cleared by por", {15'd0, wd_out}, 16'd0);
      rd(2'd3, v); chk("R1 por cause", v, 16'h0101);
      rd(2'd0, v); chk("R1 ctrl after por", v, 16'hFF32);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule